// File: doc/BRIEF.md
# Two-Level IO Address Translator

This block turns a 32-bit device bus address into a physical address for DMA. The bus address space is split into 64 regions of 32 MB. Each region has a descriptor held in an on-block register. A descriptor is one of three things: invalid, a big page that maps the whole region, or a pointer to a table in memory. A table has one 4-byte entry for each 4 KB page of the region. When a table walk is needed, the block issues a single read on a simple memory request/response port. It waits for the data and then answers with the physical address and its cached and priority attributes, or with a fault.

Software configures the block through a small write-only register port. The port holds the descriptor bank, a translation enable bit and a window-size field. The window-size field limits which bus addresses are legal. The block handles one translation at a time. Its ready output stays low from the cycle a request is taken until the cycle after the answer.

Top module: `io_xlate_walker`

## Requirements
- R1: While rst_ni is low and right after it rises, req_ready_o is 1, resp_valid_o is 0 and mem_req_o is 0. All descriptors and the enable bit reset to 0.
- R2: Translation is enabled by bit 8 of the register at offset 0x100. While that bit is clear, an accepted request is answered exactly one cycle later. The answer carries resp_paddr_o equal to the zero-extended bus address, with no fault, cached 0 and priority 0.
- R3: The descriptor of region i sits at register offset 0x2B00 + 4*i, for i from 0 to 63. Region i is selected by bus address bits [30:25]. A write to an unaligned offset, or to any offset other than these, 0x100 and 0x14C, changes nothing.
- R4: Bits [1:0] of the register at 0x14C set the window. With 0, bus addresses of 0x1000_0000 and above fault. With 1 or 3, addresses with bit 31 set fault, because the descriptors span 2 GB. With 2, every address faults.
- R5: A fault response has resp_fault_o set and resp_paddr_o, resp_cached_o and resp_prio_o all 0. A descriptor with bit 30 clear gives a fault without any memory read.
- R6: A valid descriptor with bit 31 set is a big page. The physical page number is {descriptor[29:13], bus[24:12]}, cached is descriptor bit 1 and priority is descriptor bit 0. The block answers one cycle after acceptance and makes no memory read.
- R7: A valid descriptor with bit 31 clear points to a table. The block raises mem_req_o for exactly one cycle, on the cycle after acceptance. mem_addr_o is {descriptor[29:0], 12'h000} + 4*bus[24:12].
- R8: The entry returned with mem_rvalid_i is decoded as follows: bit 31 valid, bit 30 cached, bits [29:0] physical page number. A clear valid bit gives a fault. The answer comes on the cycle after mem_rvalid_i.
- R9: On every successful translation, resp_paddr_o[11:0] equals the bus address bits [11:0].
- R10: req_ready_o is 1 only when no translation is in progress. It is 0 on the cycle after acceptance and on the answer cycle, and it is 1 again on the cycle after the answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 14 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Block idle, request is taken |
| req_addr_i | input | 32 | Bus address to translate |
| mem_req_o | output | 1 | Single-cycle table read request |
| mem_addr_o | output | 42 | Physical byte address of the table entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Table entry |
| resp_valid_o | output | 1 | Answer valid, one cycle |
| resp_fault_o | output | 1 | Translation failed |
| resp_cached_o | output | 1 | Cached attribute |
| resp_prio_o | output | 1 | Priority attribute (big pages only) |
| resp_paddr_o | output | 42 | Physical address |

## Verification
The assertions check the following on every cycle:
- ready stays low during an answer and returns on the cycle after it;
- table reads last one cycle and are word aligned;
- fault answers carry no address or attributes;
- a request taken with translation disabled comes back unchanged on the next cycle.

Some behaviour can only be shown by the bench's scenarios:
- the bit-level mapping of big pages and table entries to physical addresses;
- the window limits;
- the decoding of register offsets.

For these, the bench compares each answer and each table read address against a model built from the requirements, across directed boundary addresses and randomized descriptor banks.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int ADDR_W       = 32;
  localparam int PAGE_SHIFT   = 12;
  localparam int L1_N         = 64;
  localparam int PPN_W        = 30;
  localparam int REG_AW       = 14;
  localparam int SMALL_WIN_SH = 28;
  localparam int L1_IDX_W     = $clog2(L1_N);
  localparam int REGION_SHIFT = ADDR_W - 1 - L1_IDX_W;
  localparam int L2_IDX_W     = REGION_SHIFT - PAGE_SHIFT;
  localparam int PA_W         = PPN_W + PAGE_SHIFT;

  localparam logic [REG_AW-1:0] L1_BASE_OFF = 14'h2B00;
  localparam logic [REG_AW-1:0] CMD_OFF     = 14'h0100;
  localparam logic [REG_AW-1:0] DEC_OFF     = 14'h014C;
  localparam int EN_BIT       = 8;
  localparam int L1_TYPE_BIT  = 31;
  localparam int L1_VLD_BIT   = 30;
  localparam int L2_VLD_BIT   = 31;
  localparam int L2_CACHE_BIT = 30;

  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT, W_RESP} walk_st_e;
  typedef enum logic [1:0] {K_BYPASS, K_FAULT, K_DONE, K_WALK} l1_kind_e;

  typedef struct packed {
    logic            fault;
    logic            cached;
    logic            prio;
    logic [PA_W-1:0] paddr;
  } xlt_res_t;
endpackage

// File: rtl/xlt_cfg_regs.sv
module xlt_cfg_regs
  import xlt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [L1_IDX_W-1:0] rd_idx_i,
  output logic [31:0]         l1_o,
  output logic                en_o,
  output logic [1:0]          win_o
);
  localparam int L1_SPAN = L1_N * 4;

  logic [31:0]         l1_q [L1_N];
  logic                en_q;
  logic [1:0]          win_q;
  logic                l1_hit;
  logic [L1_IDX_W-1:0] wr_idx;

  // base is aligned to the bank span, so the index is a plain bit slice
  assign l1_hit = we_i && (addr_i[1:0] == 2'b00)
                  && (int'(addr_i) >= int'(L1_BASE_OFF))
                  && (int'(addr_i) < int'(L1_BASE_OFF) + L1_SPAN);
  assign wr_idx = addr_i[L1_IDX_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < L1_N; i++) l1_q[i] <= '0;
      en_q  <= 1'b0;
      win_q <= 2'd0;
    end else begin
      if (l1_hit) l1_q[wr_idx] <= wdata_i;
      if (we_i && addr_i == CMD_OFF) en_q  <= wdata_i[EN_BIT];
      if (we_i && addr_i == DEC_OFF) win_q <= wdata_i[1:0];
    end
  end

  assign l1_o  = l1_q[rd_idx_i];
  assign en_o  = en_q;
  assign win_o = win_q;
endmodule

// File: rtl/xlt_l1_decode.sv
module xlt_l1_decode
  import xlt_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         l1_i,
  input  logic                en_i,
  input  logic [1:0]          win_i,
  output logic [L1_IDX_W-1:0] l1_idx_o,
  output l1_kind_e            kind_o,
  output xlt_res_t            res_o,
  output logic [PA_W-1:0]     l2_addr_o
);
  logic                win_ok;
  logic [L2_IDX_W-1:0] l2_idx;

  assign l1_idx_o  = addr_i[ADDR_W-2:REGION_SHIFT];
  assign l2_idx    = addr_i[REGION_SHIFT-1:PAGE_SHIFT];
  assign l2_addr_o = {l1_i[PPN_W-1:0], {PAGE_SHIFT{1'b0}}} + PA_W'({l2_idx, 2'b00});

  always_comb begin
    unique case (win_i)
      2'd0:    win_ok = (addr_i[ADDR_W-1:SMALL_WIN_SH] == '0);
      2'd1,
      2'd3:    win_ok = !addr_i[ADDR_W-1];
      default: win_ok = 1'b0;
    endcase
  end

  always_comb begin
    res_o  = '0;
    kind_o = K_FAULT;
    if (!en_i) begin
      kind_o      = K_BYPASS;
      res_o.paddr = PA_W'(addr_i);
    end else if (!win_ok || !l1_i[L1_VLD_BIT]) begin
      kind_o      = K_FAULT;
      res_o.fault = 1'b1;
    end else if (l1_i[L1_TYPE_BIT]) begin
      kind_o       = K_DONE;
      res_o.paddr  = {l1_i[PPN_W-1:L2_IDX_W], l2_idx, addr_i[PAGE_SHIFT-1:0]};
      res_o.cached = l1_i[1];
      res_o.prio   = l1_i[0];
    end else begin
      kind_o = K_WALK;
    end
  end
endmodule

// File: rtl/xlt_walk_ctrl.sv
module xlt_walk_ctrl
  import xlt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [PAGE_SHIFT-1:0] off_i,
  input  l1_kind_e              kind_i,
  input  xlt_res_t              res_i,
  input  logic [PA_W-1:0]       l2_addr_i,
  output logic                  ready_o,
  output logic                  fire_o,
  output logic                  mem_req_o,
  output logic [PA_W-1:0]       mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [31:0]           mem_rdata_i,
  output logic                  resp_valid_o,
  output xlt_res_t              res_o
);
  walk_st_e              state_q;
  xlt_res_t              res_q, l2_res;
  logic [PAGE_SHIFT-1:0] off_q;
  logic [PA_W-1:0]       mem_addr_q;

  assign fire_o = req_valid_i && (state_q == W_IDLE);

  always_comb begin
    l2_res = '0;
    if (mem_rdata_i[L2_VLD_BIT]) begin
      l2_res.paddr  = {mem_rdata_i[PPN_W-1:0], off_q};
      l2_res.cached = mem_rdata_i[L2_CACHE_BIT];
    end else begin
      l2_res.fault = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= W_IDLE;
      res_q      <= '0;
      off_q      <= '0;
      mem_addr_q <= '0;
    end else begin
      unique case (state_q)
        W_IDLE: if (fire_o) begin
          off_q <= off_i;
          if (kind_i == K_WALK) begin
            mem_addr_q <= l2_addr_i;
            state_q    <= W_ISSUE;
          end else begin
            res_q   <= res_i;
            state_q <= W_RESP;
          end
        end
        W_ISSUE: state_q <= W_WAIT;
        W_WAIT: if (mem_rvalid_i) begin
          res_q   <= l2_res;
          state_q <= W_RESP;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == W_IDLE);
  assign mem_req_o    = (state_q == W_ISSUE);
  assign mem_addr_o   = mem_addr_q;
  assign resp_valid_o = (state_q == W_RESP);
  assign res_o        = res_q;
endmodule

// File: rtl/io_xlate_walker.sv
module io_xlate_walker
  import xlt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic              resp_cached_o,
  output logic              resp_prio_o,
  output logic [PA_W-1:0]   resp_paddr_o
);
  logic [L1_IDX_W-1:0] l1_idx;
  logic [31:0]         l1_ent;
  logic                xlt_en;
  logic [1:0]          win_sel;
  l1_kind_e            kind;
  xlt_res_t            dec_res, out_res;
  logic [PA_W-1:0]     l2_addr;
  logic                req_fire;

  xlt_cfg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rd_idx_i(l1_idx), .l1_o(l1_ent), .en_o(xlt_en), .win_o(win_sel)
  );

  xlt_l1_decode u_dec (
    .addr_i(req_addr_i), .l1_i(l1_ent), .en_i(xlt_en), .win_i(win_sel),
    .l1_idx_o(l1_idx), .kind_o(kind), .res_o(dec_res), .l2_addr_o(l2_addr)
  );

  xlt_walk_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .off_i(req_addr_i[PAGE_SHIFT-1:0]),
    .kind_i(kind), .res_i(dec_res), .l2_addr_i(l2_addr),
    .ready_o(req_ready_o), .fire_o(req_fire),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .resp_valid_o, .res_o(out_res)
  );

  assign resp_fault_o  = out_res.fault;
  assign resp_cached_o = out_res.cached;
  assign resp_prio_o   = out_res.prio;
  assign resp_paddr_o  = out_res.paddr;
endmodule

// File: rtl/xlt_walker_chk.sv
module xlt_walker_chk
  import xlt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_fire,
  input logic              xlt_en,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic [PA_W-1:0]   mem_addr_o,
  input logic              resp_valid_o,
  input logic              resp_fault_o,
  input logic              resp_cached_o,
  input logic              resp_prio_o,
  input logic [PA_W-1:0]   resp_paddr_o
);
  // R10
  busy_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);

  // R10
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> req_ready_o);

  // R7
  single_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R7
  rd_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && !req_ready_o));

  // R5
  fault_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_paddr_o == '0 && !resp_cached_o && !resp_prio_o));

  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && !xlt_en) |=> (resp_valid_o && !resp_fault_o
                               && resp_paddr_o == PA_W'($past(req_addr_i))));
endmodule

bind io_xlate_walker xlt_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_fire(req_fire), .xlt_en(xlt_en),
  .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .resp_valid_o(resp_valid_o), .resp_fault_o(resp_fault_o),
  .resp_cached_o(resp_cached_o), .resp_prio_o(resp_prio_o),
  .resp_paddr_o(resp_paddr_o)
);

// File: tb/tb_io_xlate_walker.sv
`timescale 1ns/1ps
module tb_io_xlate_walker;
  import xlt_pkg::*;

  logic clk, rst_n;
  logic cfg_we; logic [13:0] cfg_addr; logic [31:0] cfg_wdata;
  logic req_valid, req_ready; logic [31:0] req_addr;
  logic mem_req, mem_rvalid; logic [41:0] mem_addr; logic [31:0] mem_rdata;
  logic resp_valid, resp_fault, resp_cached, resp_prio; logic [41:0] resp_paddr;

  int checks = 0, errors = 0, mem_reads = 0;
  logic [31:0] l1m [64];
  logic        en_m;
  logic [1:0]  win_m;
  logic [41:0] last_rd;

  io_xlate_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .resp_valid_o(resp_valid), .resp_fault_o(resp_fault),
    .resp_cached_o(resp_cached), .resp_prio_o(resp_prio), .resp_paddr_o(resp_paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [41:0] a);
    return {~(a[2] & a[3]), a[4], a[31:2] ^ 30'h0155AA};
  endfunction

  function automatic bit win_ok(logic [31:0] a);
    case (win_m)
      2'd0: return a[31:28] == 4'd0;
      2'd2: return 1'b0;
      default: return !a[31];
    endcase
  endfunction

  function automatic bit walks(logic [31:0] a);
    logic [31:0] e = l1m[a[30:25]];
    return en_m && win_ok(a) && e[30] && !e[31];
  endfunction

  function automatic logic [41:0] l2_addr(logic [31:0] a);
    logic [31:0] e = l1m[a[30:25]];
    return {e[29:0], 12'h000} + {27'd0, a[24:12], 2'b00};
  endfunction

  function automatic xlt_res_t expect_x(logic [31:0] a);
    xlt_res_t r; logic [31:0] e, w;
    r = '0;
    if (!en_m) begin r.paddr = {10'd0, a}; return r; end
    e = l1m[a[30:25]];
    if (!win_ok(a) || !e[30]) begin r.fault = 1'b1; return r; end
    if (e[31]) begin
      r.paddr = {e[29:13], a[24:0]}; r.cached = e[1]; r.prio = e[0];
    end else begin
      w = mem_word(l2_addr(a));
      if (!w[31]) r.fault = 1'b1;
      else begin r.paddr = {w[29:0], a[11:0]}; r.cached = w[30]; end
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [13:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    if (a == 14'h100) en_m = d[8];
    if (a == 14'h14C) win_m = d[1:0];
    if (a[1:0] == 2'b00 && a >= 14'h2B00 && a < 14'h2C00) l1m[a[7:2]] = d;
  endtask

  // memory responder: answers each read after 1 to 4 cycles
  initial begin
    mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        mem_reads++;
        last_rd = mem_addr;
        repeat (1 + $urandom_range(0, 3)) @(negedge clk);
        mem_rdata = mem_word(last_rd); mem_rvalid = 1'b1;
        @(negedge clk); mem_rvalid = 1'b0;
      end
    end
  end

  task automatic run_one(logic [31:0] a, string req);
    xlt_res_t exp, got; int lat, rd0; bit wk;
    exp = expect_x(a); wk = walks(a); rd0 = mem_reads;
    @(negedge clk);
    chk(req_ready, "R10", "ready when idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    chk(!req_ready, "R10", "ready after accept", {63'd0, req_ready}, 64'd0);
    lat = 1;
    while (!resp_valid && lat < 100) begin @(negedge clk); lat++; end
    if (!resp_valid) begin
      chk(1'b0, req, "response timeout", 64'd0, 64'd1);
      return;
    end
    got = {resp_fault, resp_cached, resp_prio, resp_paddr};
    chk(got == exp, req, $sformatf("result for %h", a), 64'(got), 64'(exp));
    if (wk) begin
      chk(last_rd == l2_addr(a), "R7", "table read address", 64'(last_rd), 64'(l2_addr(a)));
      chk(mem_reads == rd0 + 1, "R7", "one read", 64'(mem_reads - rd0), 64'd1);
    end else begin
      chk(lat == 1, req, "direct latency", 64'(lat), 64'd1);
      chk(mem_reads == rd0, "R5/R6", "no read", 64'(mem_reads - rd0), 64'd0);
    end
    @(negedge clk);
    chk(req_ready, "R10", "ready after answer", {63'd0, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) l1m[i] = '0;
    en_m = 1'b0; win_m = 2'd0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; req_valid = 1'b0; req_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1", "reset outputs",
        {61'd0, req_ready, resp_valid, mem_req}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1", "after reset",
        {61'd0, req_ready, resp_valid, mem_req}, 64'h4);

    // R2 bypass while disabled
    run_one(32'h8765_4321, "R2");
    run_one(32'h0000_0ABC, "R2");

    cfg_write(14'h2B00, 32'h4001_2345);          // region 0: table
    cfg_write(14'h2B04, 32'hC246_0003);          // region 1: big page
    cfg_write(14'h2B08, 32'h0000_1234);          // region 2: invalid
    cfg_write(14'h2B1C, 32'hC001_E002);          // region 7: big page
    cfg_write(14'h2BFC, 32'h4000_0ABC);          // region 63: table
    cfg_write(14'h014C, 32'h0000_0001);
    cfg_write(14'h0100, 32'h0000_0100);
    // R3 stray writes must not touch region 0
    cfg_write(14'h2C00, 32'hFFFF_FFFF);
    cfg_write(14'h2B01, 32'hFFFF_FFFF);
    cfg_write(14'h2AFC, 32'hFFFF_FFFF);

    run_one(32'h0000_5678, "R3");
    run_one(32'h0000_3000, "R8");                // invalid second-level entry
    run_one(32'h0200_0ABC, "R6");
    run_one(32'h0400_0000, "R5");
    run_one(32'h7FFF_F123, "R7");
    run_one(32'h8000_0000, "R4");
    cfg_write(14'h014C, 32'h0000_0000);
    run_one(32'h0FFF_FFFF, "R4");
    run_one(32'h1000_0000, "R4");
    cfg_write(14'h014C, 32'h0000_0002);
    run_one(32'h0000_0010, "R4");
    cfg_write(14'h014C, 32'h0000_0003);
    run_one(32'h7FFF_F123, "R4");
    run_one(32'hFFFF_FFFF, "R4");

    // random banks and addresses
    for (int round = 0; round < 6; round++) begin
      for (int i = 0; i < 64; i++) begin
        logic [31:0] d = $urandom;
        d[30] = ($urandom_range(0, 3) != 0);
        cfg_write(14'h2B00 + 14'(i * 4), d);
      end
      cfg_write(14'h014C, 32'($urandom_range(0, 3)));
      cfg_write(14'h0100, (round == 3) ? 32'h0 : 32'h100);
      for (int n = 0; n < 50; n++) begin
        logic [31:0] a = $urandom;
        if ($urandom_range(0, 7) != 0) a[31] = 1'b0;
        if ($urandom_range(0, 3) == 0) a[31:28] = 4'd0;
        run_one(a, "R8/R9");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule